// File: doc/BRIEF.md
# Four-Dimensional Strided Address Generator

This block turns one access descriptor into the ordered list of element addresses for a walk over a multi-dimensional array held in linear memory. The descriptor holds a base address and four stride/size pairs, one pair per loop level. Level 1 is the innermost loop and level 4 the outermost. Every level carries its own stride, so any array axis can be placed at any loop level. One engine can therefore produce plain sub-cuboid reads, transposed orders and fully permuted orders. Addresses count elements, not bytes.

Software or a fetch engine writes the nine descriptor words one at a time through a small write port, then pulses `start`. The generator presents addresses on a valid/ready stream. It flags the final address with `addr_last` and pulses `done` once that address has been taken. Each step adds a stride to a saved per-level start address, so the datapath needs no multipliers. All sums are 64-bit and wrap modulo 2^64.

Top module: `strided_walk_gen`

## Requirements
- R1: Descriptor word index 0 holds the base. For loop level k (1 innermost to 4 outermost), index 2k-1 holds that level's stride and index 2k holds its size. A word is written when `cfg_we` is high at a clock edge, at index `cfg_idx` with value `cfg_data`.
- R2: Each emitted address equals base + d1*stride1 + d2*stride2 + d3*stride3 + d4*stride4, taken modulo 2^64.
- R3: Each index dk runs from 0 to size_k-1. d1 advances on every accepted address, and each outer index advances when the index just inside it wraps. The walk emits exactly size1*size2*size3*size4 addresses.
- R4: A `start` pulse while idle makes `addr_valid` high from the next cycle, with `addr` equal to the base.
- R5: If any of the four sizes is 0, a `start` produces no address. `done` goes high in the cycle after `start`, and `busy` stays low.
- R6: `addr_last` is high together with `addr_valid` on the final address of the walk and on no other address.
- R7: While `addr_valid` is high and `addr_ready` is low, `addr` and `addr_last` hold their values and `addr_valid` stays high.
- R8: `done` is high for exactly one cycle: the cycle after the final address is accepted. In that cycle `addr_valid` and `busy` are low.
- R9: While `busy` is high, `start` pulses and descriptor writes are ignored. The walk in progress continues unchanged, and the stored descriptor keeps its earlier contents.
- R10: A stride of 0 leaves the address unchanged as that level's index advances.
- R11: After reset, `addr_valid`, `addr_last`, `done` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Descriptor word write enable |
| cfg_idx | input | 4 | Descriptor word index (0 to 8) |
| cfg_data | input | 64 | Descriptor word value |
| start | input | 1 | Begin a walk with the stored descriptor |
| busy | output | 1 | Walk in progress |
| addr_valid | output | 1 | Address available |
| addr_ready | input | 1 | Consumer accepts the address |
| addr | output | 64 | Element address |
| addr_last | output | 1 | Final address of the walk |
| done | output | 1 | One-cycle pulse after the final address is accepted |

## Verification
The bench sweeps every combination of sizes 1 to 3 on all four levels, under stalling ready patterns. A design that wraps a level at the wrong count, or carries into the wrong level, then produces a wrong address or a wrong total. It also runs:
- a transposed walk, where a wrong carry reload leaves the address stuck on the last row's start;
- a zero stride, where a wrong design drifts the address;
- a base and stride near 2^64, where a wrong design saturates instead of wrapping;
- a zero size at each level, where a wrong design emits a huge or bogus sequence instead of an immediate `done`.

Stalls with a restart attempt and a descriptor rewrite in the middle of a walk catch a design that drops or changes addresses while ready is low, or lets a busy walk be disturbed.

// File: rtl/stw_pkg.sv
package stw_pkg;
    parameter int unsigned ADDR_W = 64;
    parameter int unsigned LEVELS = 4;
    localparam int unsigned WORDS  = 2 * LEVELS + 1;
    localparam int unsigned CIDX_W = $clog2(WORDS);

    typedef logic [ADDR_W-1:0] word_t;

    typedef struct packed {
        word_t stride;
        word_t size;
    } level_cfg_t;

    typedef struct packed {
        word_t                   base;
        level_cfg_t [LEVELS-1:0] lvl;
    } desc_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } walk_state_t;

    // True when at least one loop level has zero iterations
    function automatic logic any_size_zero(input desc_t d);
        logic z;
        z = 1'b0;
        for (int k = 0; k < int'(LEVELS); k++) begin
            if (d.lvl[k].size == '0) z = 1'b1;
        end
        return z;
    endfunction
endpackage

// File: rtl/stw_desc_file.sv
module stw_desc_file
    import stw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CIDX_W-1:0] wr_idx,
    input  word_t             wr_data,
    output desc_t             desc
);
    word_t words [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(WORDS); i++) words[i] <= '0;
        end else if (wr_en && (32'(wr_idx) < WORDS)) begin
            words[wr_idx] <= wr_data;
        end
    end

    assign desc.base = words[0];

    // Word 2k+1 is the stride and 2k+2 the size of level k (0 = innermost)
    for (genvar k = 0; k < int'(LEVELS); k++) begin : g_map
        assign desc.lvl[k].stride = words[2*k+1];
        assign desc.lvl[k].size   = words[2*k+2];
    end
endmodule

// File: rtl/stw_index_chain.sv
module stw_index_chain
    import stw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              step,
    input  word_t             sizes [LEVELS],
    output logic [LEVELS-1:0] carry_sel,
    output logic              at_end
);
    word_t             idx  [LEVELS];
    logic [LEVELS-1:0] wrap;
    logic [LEVELS-1:0] reset_lvl;

    for (genvar k = 0; k < int'(LEVELS); k++) begin : g_wrap
        assign wrap[k] = (idx[k] == sizes[k] - word_t'(1));
    end

    // Lowest level that has not reached its final index takes the increment
    always_comb begin
        logic found;
        found     = 1'b0;
        carry_sel = '0;
        for (int k = 0; k < int'(LEVELS); k++) begin
            if (!found && !wrap[k]) begin
                carry_sel[k] = 1'b1;
                found        = 1'b1;
            end
        end
    end

    assign at_end = &wrap;

    for (genvar k = 0; k < int'(LEVELS); k++) begin : g_idx
        // Levels below the incrementing one restart at zero
        assign reset_lvl[k] = |(carry_sel >> (k + 1));

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                idx[k] <= '0;
            end else if (step && !at_end) begin
                if (carry_sel[k])      idx[k] <= idx[k] + word_t'(1);
                else if (reset_lvl[k]) idx[k] <= '0;
            end
        end
    end
endmodule

// File: rtl/stw_mark_bank.sv
module stw_mark_bank
    import stw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  word_t             base,
    input  word_t             strides [LEVELS],
    input  logic [LEVELS-1:0] carry_sel,
    output word_t             cur_addr
);
    // mark[k]: address with the indices below level k at zero
    word_t mark [LEVELS];
    word_t next_mark;

    always_comb begin
        next_mark = mark[0];
        for (int k = 0; k < int'(LEVELS); k++) begin
            if (carry_sel[k]) next_mark = mark[k] + strides[k];
        end
    end

    for (genvar k = 0; k < int'(LEVELS); k++) begin : g_mark
        always_ff @(posedge clk) begin
            if (rst) begin
                mark[k] <= '0;
            end else if (load) begin
                mark[k] <= base;
            end else if (step && ((carry_sel >> k) != '0)) begin
                mark[k] <= next_mark;
            end
        end
    end

    assign cur_addr = mark[0];
endmodule

// File: rtl/strided_walk_gen.sv
module strided_walk_gen
    import stw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CIDX_W-1:0] cfg_idx,
    input  logic [ADDR_W-1:0] cfg_data,
    input  logic              start,
    output logic              busy,
    output logic              addr_valid,
    input  logic              addr_ready,
    output logic [ADDR_W-1:0] addr,
    output logic              addr_last,
    output logic              done
);
    walk_state_t       state;
    logic              done_q;
    desc_t             desc;
    word_t             sizes   [LEVELS];
    word_t             strides [LEVELS];
    logic [LEVELS-1:0] carry_sel;
    logic              at_end;
    logic              size_zero;
    logic              start_ok;
    logic              launch;
    logic              accept;

    assign start_ok  = start && (state == ST_IDLE);
    assign size_zero = any_size_zero(desc);
    assign launch    = start_ok && !size_zero;
    assign accept    = addr_valid && addr_ready;

    stw_desc_file u_desc (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we && (state == ST_IDLE)),
        .wr_idx  (cfg_idx),
        .wr_data (cfg_data),
        .desc    (desc)
    );

    for (genvar k = 0; k < int'(LEVELS); k++) begin : g_unpack
        assign sizes[k]   = desc.lvl[k].size;
        assign strides[k] = desc.lvl[k].stride;
    end

    stw_index_chain u_idx (
        .clk       (clk),
        .rst       (rst),
        .clear     (launch),
        .step      (accept),
        .sizes     (sizes),
        .carry_sel (carry_sel),
        .at_end    (at_end)
    );

    stw_mark_bank u_mark (
        .clk       (clk),
        .rst       (rst),
        .load      (launch),
        .step      (accept),
        .base      (desc.base),
        .strides   (strides),
        .carry_sel (carry_sel),
        .cur_addr  (addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start_ok) begin
                        if (size_zero) done_q <= 1'b1;
                        else           state  <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (accept && at_end) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state == ST_RUN);
    assign addr_valid = busy;
    assign addr_last  = busy && at_end;
    assign done       = done_q;
endmodule

// File: rtl/stw_checker.sv
module stw_checker
    import stw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              addr_valid,
    input logic              addr_ready,
    input logic [ADDR_W-1:0] addr,
    input logic              addr_last,
    input logic              done,
    input logic              size_zero
);
    // R7
    a_r7_hold_stall: assert property (@(posedge clk) disable iff (rst)
        addr_valid && !addr_ready |=> addr_valid && $stable(addr) && $stable(addr_last));

    // R8
    a_r8_done_after_last: assert property (@(posedge clk) disable iff (rst)
        addr_valid && addr_ready && addr_last |=> done && !addr_valid && !busy);

    // R8
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done && !start |=> !done);

    // R5
    a_r5_zero_size: assert property (@(posedge clk) disable iff (rst)
        start && !busy && size_zero |=> done && !addr_valid && !busy);

    // R4
    a_r4_first_valid: assert property (@(posedge clk) disable iff (rst)
        start && !busy && !size_zero |=> addr_valid && !done);

    // R9
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
        busy && start && !addr_ready |=> busy && $stable(addr));

    // R6
    a_r6_last_with_valid: assert property (@(posedge clk) disable iff (rst)
        addr_last |-> addr_valid);
endmodule

bind strided_walk_gen stw_checker u_stw_chk (.*);

// File: tb/strided_walk_gen_bench.sv
`timescale 1ns/1ps
module strided_walk_gen_bench;
    import stw_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              cfg_we;
    logic [CIDX_W-1:0] cfg_idx;
    logic [ADDR_W-1:0] cfg_data;
    logic              start;
    logic              busy;
    logic              addr_valid;
    logic              addr_ready;
    logic [ADDR_W-1:0] addr;
    logic              addr_last;
    logic              done;

    always #2.5 clk = ~clk;

    strided_walk_gen u_strided_walk_gen (.*);

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cyc      = 0;
    bit    finished = 1'b0;
    word_t cur_b;
    word_t cur_s [4];
    word_t cur_n [4];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input word_t act, input word_t exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic rdy_pat(input int c, input int mode);
        case (mode)
            0:       return 1'b1;
            1:       return (c % 3) != 0;
            default: return ((c / 2) % 2) == 1;
        endcase
    endfunction

    task automatic write_word(input int i, input word_t v);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_idx  = CIDX_W'(i);
        cfg_data = v;
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    // R1: index 0 base, 2k-1 stride and 2k size of level k
    task automatic load_cur();
        write_word(0, cur_b);
        for (int k = 0; k < 4; k++) begin
            write_word(2*k + 1, cur_s[k]);
            write_word(2*k + 2, cur_n[k]);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Starts and ends at a negedge; the accept happens at the posedge between
    task automatic consume(input word_t exp, input bit exp_last, input int mode, input string tag);
        int g;
        bit got;
        g   = 0;
        got = 1'b0;
        while (!got && g < 500) begin
            addr_ready = rdy_pat(cyc, mode);
            if (addr_valid && addr_ready) begin
                check(addr == exp, tag, addr, exp);
                check(addr_last == exp_last, "R6 last flag", word_t'(addr_last), word_t'(exp_last));
                got = 1'b1;
            end
            @(negedge clk);
            g++;
        end
        if (!got) check(1'b0, {tag, " no address"}, word_t'(addr_valid), 64'd1);
    endtask

    task automatic run_cur(input int mode, input string tag);
        word_t total;
        word_t k;
        word_t e;
        total = cur_n[0] * cur_n[1] * cur_n[2] * cur_n[3];
        load_cur();
        pulse_start();
        if (total == 0) begin
            check(done == 1'b1 && addr_valid == 1'b0 && busy == 1'b0, "R5 zero size done",
                  {61'd0, done, addr_valid, busy}, 64'h4);
            @(negedge clk);
            check(done == 1'b0 && addr_valid == 1'b0, "R5 no address after done",
                  {62'd0, done, addr_valid}, 64'h0);
        end else begin
            k = 0;
            for (int d4 = 0; d4 < int'(cur_n[3]); d4++)
                for (int d3 = 0; d3 < int'(cur_n[2]); d3++)
                    for (int d2 = 0; d2 < int'(cur_n[1]); d2++)
                        for (int d1 = 0; d1 < int'(cur_n[0]); d1++) begin
                            e = cur_b + word_t'(d1) * cur_s[0] + word_t'(d2) * cur_s[1]
                                      + word_t'(d3) * cur_s[2] + word_t'(d4) * cur_s[3];
                            k = k + 1;
                            consume(e, k == total, mode, tag);
                        end
            addr_ready = 1'b0;
            check(done == 1'b1 && addr_valid == 1'b0 && busy == 1'b0, "R8 done after last",
                  {61'd0, done, addr_valid, busy}, 64'h4);
            @(negedge clk);
            check(done == 1'b0, "R8 done one cycle", word_t'(done), 64'd0);
        end
    endtask

    task automatic set_cur(input word_t b, input word_t s0, input word_t s1, input word_t s2,
                           input word_t s3, input word_t n0, input word_t n1, input word_t n2,
                           input word_t n3);
        cur_b = b;
        cur_s[0] = s0; cur_s[1] = s1; cur_s[2] = s2; cur_s[3] = s3;
        cur_n[0] = n0; cur_n[1] = n1; cur_n[2] = n2; cur_n[3] = n3;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst        = 1'b1;
        cfg_we     = 1'b0;
        cfg_idx    = '0;
        cfg_data   = '0;
        start      = 1'b0;
        addr_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11
        check(addr_valid == 0 && addr_last == 0 && done == 0 && busy == 0, "R11 reset state",
              {60'd0, addr_valid, addr_last, done, busy}, 64'h0);

        // R2 R3: worked example, 24 addresses starting 4,5,6,7,12
        set_cur(64'd4, 64'd1, 64'd8, 64'd56, 64'd0, 64'd4, 64'd3, 64'd2, 64'd1);
        run_cur(0, "R2 R3 sub-cuboid");

        // R3: transposed walk, row stride innermost
        set_cur(64'd0, 64'd8, 64'd1, 64'd56, 64'd0, 64'd7, 64'd8, 10, 64'd1);
        run_cur(1, "R3 transposed");

        // R3 R1: sweep all size combinations 1..3 on four levels
        for (int a = 1; a <= 3; a++)
            for (int b = 1; b <= 3; b++)
                for (int c = 1; c <= 3; c++)
                    for (int d = 1; d <= 3; d++) begin
                        set_cur(64'd1000 + word_t'(a), 64'd3, 64'd1, 64'd40, 64'd7,
                                word_t'(a), word_t'(b), word_t'(c), word_t'(d));
                        run_cur((a + b + c + d) % 3, "R3 R1 sweep");
                    end

        // R10: zero strides on two levels
        set_cur(64'd500, 64'd0, 64'd1, 64'd0, 64'd9, 64'd2, 64'd3, 64'd2, 64'd2);
        run_cur(2, "R10 zero stride");

        // R2: wrap modulo 2^64
        set_cur(64'hFFFF_FFFF_FFFF_FFFE, 64'd1, 64'hFFFF_FFFF_FFFF_FFF0, 64'd3, 64'd0,
                64'd4, 64'd2, 64'd2, 64'd1);
        run_cur(1, "R2 wrap");

        // R5: zero size at each level in turn
        for (int z = 0; z < 4; z++) begin
            set_cur(64'd77, 64'd1, 64'd2, 64'd3, 64'd4, 64'd2, 64'd2, 64'd2, 64'd2);
            cur_n[z] = 64'd0;
            run_cur(0, "R5 zero size");
        end

        // R7 R4 R9: stall, restart attempt and descriptor rewrite while busy
        set_cur(64'd100, 64'd1, 64'd0, 64'd0, 64'd0, 64'd3, 64'd1, 64'd1, 64'd1);
        load_cur();
        addr_ready = 1'b0;
        pulse_start();
        check(addr_valid == 1'b1 && addr == 64'd100, "R4 first address is base", addr, 64'd100);
        cfg_we   = 1'b1;
        cfg_idx  = '0;
        cfg_data = 64'd999;
        start    = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        start  = 1'b0;
        for (int h = 0; h < 3; h++) begin
            check(addr_valid == 1'b1 && addr == 64'd100 && busy == 1'b1, "R7 R9 hold under stall",
                  addr, 64'd100);
            @(negedge clk);
        end
        consume(64'd100, 1'b0, 0, "R7 after stall");
        consume(64'd101, 1'b0, 0, "R9 walk undisturbed");
        consume(64'd102, 1'b1, 0, "R9 walk undisturbed");
        addr_ready = 1'b0;
        check(done == 1'b1, "R8 done after stalled walk", word_t'(done), 64'd1);
        pulse_start();
        check(addr == 64'd100, "R9 descriptor write ignored while busy", addr, 64'd100);
        consume(64'd100, 1'b0, 0, "R9 rerun");
        consume(64'd101, 1'b0, 0, "R9 rerun");
        consume(64'd102, 1'b1, 0, "R9 rerun");
        addr_ready = 1'b0;

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule